// File: doc/BRIEF.md
# Radix-4 Trace-Back Survivor Memory

This block sits behind the add-compare-select array of a four-state radix-4 trellis decoder. On every step that the array finishes, it takes one column of survivor decisions, holding a 2-bit predecessor choice for each of the four states, and writes that column into a circular column memory. Once enough history has built up, a trace-back walk starts at state 0 in the newest column. The first part of the walk runs back through a merge window deep enough that every survivor has reached the common path. The walk then continues through a decode window and yields one decoded state per column.

The trace-back visits the decode window from newest to oldest, so each decoded state goes onto a small stack as it is found. The stack is then emptied onto the output, which restores time order. Each decoded state is the pair of input bits for its step. The column memory holds merge depth plus twice the decode depth, so the next decode window can be written while the current trace-back is running. The producer has to space its columns so that one decode window of writes takes at least as many cycles as a full trace-back plus the drain.

Top module: `tbk_survivor_mem`

## Requirements
- R1: Synchronous reset clears the block. While reset is held and afterwards, `outValid` is low, and a trace-back or drain cut off by reset produces no output.
- R2: A column is stored only in a cycle where `inValid` is high. The value on `decIn` in other cycles has no effect on any output.
- R3: `outValid` stays low until MERGE_L+DECODE_D columns have been written since reset.
- R4: After the first trace-back, a new trace-back is triggered by every DECODE_D further columns. Each trace-back yields exactly DECODE_D output pairs.
- R5: Each trace-back begins at state 0 in the column written on the triggering edge, and then follows MERGE_L predecessor links before it decodes anything.
- R6: The predecessor of state s in a column is the 2-bit field at bits [2s+1:2s] of that column.
- R7: The decoded pair for a step is that step's state. Bit 1 is the earlier input bit and bit 0 is the later one.
- R8: The DECODE_D pairs of a burst appear on consecutive cycles in ascending time order. The first pair appears MERGE_L+DECODE_D cycles after the edge that stored the triggering column.
- R9: The column memory is MERGE_L+2*DECODE_D deep. When columns are spaced so that DECODE_D writes span at least that many cycles, a trigger never arrives while a trace-back or drain is still running.
- R10: With noise-free decisions, where every state in column j points to the true state of step j-1 and the state before step 0 is 0, the output reproduces the input pair stream. The burst triggered after c writes covers steps c-MERGE_L-DECODE_D to c-MERGE_L-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A decision column is present on `decIn` |
| decIn | input | 8 | Four 2-bit predecessor fields; the field for state s is at [2s+1:2s] |
| outValid | output | 1 | A decoded pair is present on `outPair` |
| outPair | output | 2 | Decoded input bits of one step; bit 1 is the earlier bit |

## Verification
Several properties are checked on every cycle by the assertions:
- A trigger never lands on a busy trace-back (the pacing rule).
- The stack never overflows or underflows, pushes and pops never share a cycle, and the stack is exactly empty when a burst ends.
- The walk always starts from state 0 with the read pointer on the newest column.
- No output appears before the priming count has been reached.

Only the bench's scenarios can show the following:
- Decoded pairs match the input stream under noise-free decisions.
- Arbitrary decision patterns are followed field by field through the merge window.
- Bursts land on the stated cycle.
- Column data offered without a strobe leaves the output untouched.

// File: rtl/tbk_pkg.sv
package tbk_pkg;
  localparam int STATES = 4;
  localparam int SW     = 2;
  localparam int COL_W  = STATES * SW;

  typedef logic [SW-1:0] state_t;

  typedef struct packed {
    logic wrEn;
    logic loadStart;
    logic step;
    logic push;
    logic pop;
  } tbStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRACE = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;
endpackage

// File: rtl/tbk_ctrl.sv
module tbk_ctrl
  import tbk_pkg::*;
#(
  parameter int MERGE_L  = 15,
  parameter int DECODE_D = 8
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         inValid,
  output tbStrobe_t                                    strb,
  output logic [$clog2(MERGE_L+2*DECODE_D)-1:0]        wrAddr,
  output logic [$clog2(MERGE_L+2*DECODE_D)-1:0]        rdAddr,
  output logic                                         outValid
);
  localparam int DEPTH  = MERGE_L + 2*DECODE_D;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int RUN    = MERGE_L + DECODE_D;
  localparam int RUN_W  = $clog2(RUN + 1);

  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [RUN_W-1:0]  untilTrig, stepCnt;
  phase_t            phase;
  logic              trig;

  assign trig = inValid && (untilTrig == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      untilTrig <= RUN_W'(RUN - 1);
      stepCnt   <= '0;
      phase     <= PH_IDLE;
    end else begin
      if (inValid) begin
        wrPtr     <= (wrPtr == ADDR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        untilTrig <= (untilTrig == '0) ? RUN_W'(DECODE_D - 1) : untilTrig - 1'b1;
      end
      case (phase)
        PH_IDLE: begin
          if (trig) begin
            phase   <= PH_TRACE;
            stepCnt <= '0;
            rdPtr   <= wrPtr;
          end
        end
        PH_TRACE: begin
          rdPtr <= (rdPtr == '0) ? ADDR_W'(DEPTH - 1) : rdPtr - 1'b1;
          if (stepCnt == RUN_W'(RUN - 1)) begin
            phase   <= PH_DRAIN;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        PH_DRAIN: begin
          if (stepCnt == RUN_W'(DECODE_D - 1)) begin
            phase   <= PH_IDLE;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.wrEn      = inValid;
    strb.loadStart = trig && (phase == PH_IDLE);
    strb.step      = (phase == PH_TRACE);
    strb.push      = (phase == PH_TRACE) && (stepCnt >= RUN_W'(MERGE_L));
    strb.pop       = (phase == PH_DRAIN);
  end

  assign wrAddr   = wrPtr;
  assign rdAddr   = rdPtr;
  assign outValid = (phase == PH_DRAIN);

  // Checker-only count of columns written since reset, saturating at RUN.
  logic [RUN_W-1:0] seenCnt;
  always_ff @(posedge clk) begin
    if (rst) seenCnt <= '0;
    else if (inValid && seenCnt != RUN_W'(RUN)) seenCnt <= seenCnt + 1'b1;
  end

  // R9: producer pacing keeps triggers away from a busy walk
  p_pacing_r9: assert property (@(posedge clk) disable iff (rst)
    trig |-> (phase == PH_IDLE));

  // R3: no output before the priming count
  p_quiet_until_primed_r3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (seenCnt == RUN_W'(RUN)));

  // R5: walk starts on the column stored at the trigger edge
  p_start_newest_r5: assert property (@(posedge clk) disable iff (rst)
    strb.loadStart |=> (rdAddr == $past(wrAddr)));
endmodule

// File: rtl/tbk_path.sv
module tbk_path
  import tbk_pkg::*;
#(
  parameter int MERGE_L  = 15,
  parameter int DECODE_D = 8
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  tbStrobe_t                                    strb,
  input  logic [$clog2(MERGE_L+2*DECODE_D)-1:0]        wrAddr,
  input  logic [$clog2(MERGE_L+2*DECODE_D)-1:0]        rdAddr,
  input  logic [COL_W-1:0]                             decIn,
  output state_t                                       outPair
);
  localparam int DEPTH = MERGE_L + 2*DECODE_D;
  localparam int SP_W  = $clog2(DECODE_D + 1);
  localparam int IDX_W = (DECODE_D > 1) ? $clog2(DECODE_D) : 1;

  logic [COL_W-1:0] colMem [DEPTH];
  logic [COL_W-1:0] rdCol;
  state_t           fld [STATES];
  state_t           traceState, pred;
  state_t           lifo [DECODE_D];
  logic [SP_W-1:0]  sp;
  logic [IDX_W-1:0] topIdx;

  always_ff @(posedge clk) begin
    if (strb.wrEn) colMem[wrAddr] <= decIn;
  end

  assign rdCol = colMem[rdAddr];

  for (genvar g = 0; g < STATES; g++) begin : g_field
    assign fld[g] = rdCol[g*SW +: SW];
  end

  assign pred = fld[traceState];

  always_ff @(posedge clk) begin
    if (rst)                 traceState <= '0;
    else if (strb.loadStart) traceState <= '0;
    else if (strb.step)      traceState <= pred;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (strb.push) begin
      lifo[sp[IDX_W-1:0]] <= traceState;
      sp <= sp + 1'b1;
    end else if (strb.pop) begin
      sp <= sp - 1'b1;
    end
  end

  assign topIdx  = (sp == '0) ? '0 : IDX_W'(sp - 1'b1);
  assign outPair = lifo[topIdx];

  // R8: stack bounds and burst closure
  p_lifo_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    strb.push |-> (sp < SP_W'(DECODE_D)));
  p_lifo_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    strb.pop |-> (sp != '0));
  p_one_direction_r8: assert property (@(posedge clk) disable iff (rst)
    !(strb.push && strb.pop));
  p_drained_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(strb.pop) |-> (sp == '0));
  // R5: walk begins from state 0
  p_start_zero_r5: assert property (@(posedge clk) disable iff (rst)
    strb.loadStart |=> (traceState == '0));
endmodule

// File: rtl/tbk_survivor_mem.sv
module tbk_survivor_mem
  import tbk_pkg::*;
#(
  parameter int MERGE_L  = 15,
  parameter int DECODE_D = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] decIn,
  output logic       outValid,
  output logic [1:0] outPair
);
  localparam int ADDR_W = $clog2(MERGE_L + 2*DECODE_D);

  tbStrobe_t         strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  tbk_ctrl #(.MERGE_L(MERGE_L), .DECODE_D(DECODE_D)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .outValid (outValid)
  );

  tbk_path #(.MERGE_L(MERGE_L), .DECODE_D(DECODE_D)) u_path (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .decIn   (decIn),
    .outPair (outPair)
  );
endmodule

// File: tb/tb_tbk_survivor_mem.sv
module tb_tbk_survivor_mem;
  localparam int CLK_PERIOD = 10;
  localparam int L   = 15;
  localparam int D   = 8;
  localparam int RUN = L + D;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] decIn = '0;
  logic       outValid;
  logic [1:0] outPair;

  tbk_survivor_mem #(.MERGE_L(L), .DECODE_D(D)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .decIn(decIn),
    .outValid(outValid), .outPair(outPair)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int         errors = 0;
  int         checks = 0;
  int         cyc = 0;
  int         nW = 0;
  int         outSeen = 0;
  bit         prevValid = 0;
  bit         useTruth = 0;
  bit         done = 0;
  string      curReq = "R6";
  logic [7:0] cols  [0:1023];
  logic [1:0] truth [0:1023];
  logic [1:0] expQ [$];
  int         burstQ [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    @(negedge clk);
    if (outValid) begin
      outSeen++;
      if (!prevValid) begin
        if (burstQ.size() == 0) check(0, "R3 burst with no trigger", cyc, -1);
        else begin
          int e = burstQ.pop_front();
          check(cyc == e, "R8 burst start cycle", cyc, e);
        end
      end
      if (expQ.size() == 0) check(0, "R3 R4 unexpected pair", int'(outPair), -1);
      else begin
        logic [1:0] ex = expQ.pop_front();
        check(outPair == ex, curReq, int'(outPair), int'(ex));
      end
    end
    prevValid = outValid;
  endtask

  task automatic schedule(input int c);
    int st = 0;
    logic [1:0] tmp [0:D-1];
    for (int j = c - 1; j >= c - L; j--) st = int'(cols[j][2*st +: 2]);
    for (int k = c - 1 - L; k >= c - L - D; k--) begin
      tmp[k - (c - L - D)] = useTruth ? truth[k] : 2'(st);
      st = int'(cols[k][2*st +: 2]);
    end
    for (int i = 0; i < D; i++) expQ.push_back(tmp[i]);
    burstQ.push_back(cyc + RUN);
  endtask

  task automatic writeCol(input logic [7:0] col, input int gap);
    inValid = 1'b1;
    decIn   = col;
    cols[nW] = col;
    tick();
    nW++;
    if (nW >= RUN && ((nW - RUN) % D) == 0) schedule(nW);
    inValid = 1'b0;
    for (int g = 1; g < gap; g++) begin
      decIn = 8'($urandom);   // R2: garbage without strobe
      tick();
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    inValid = 1'b0;
    expQ.delete();
    burstQ.delete();
    for (int i = 0; i < 3; i++) begin
      tick();
      check(outValid == 1'b0, "R1 output low in reset", int'(outValid), 0);
    end
    rst = 1'b0;
    nW = 0;
    prevValid = 0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < L + 2*D + 4; i++) tick();
    check(expQ.size() == 0, req, expQ.size(), 0);
    check(burstQ.size() == 0, req, burstQ.size(), 0);
  endtask

  initial begin
    @(negedge clk);
    doReset();
    for (int i = 0; i < 4; i++) begin
      tick();
      check(outValid == 1'b0, "R1 idle after reset", int'(outValid), 0);
    end

    // Scenario A: noise-free decisions, output must equal input pairs (R7, R10)
    useTruth = 1;
    curReq = "R7 R10 decoded pair";
    begin
      logic [1:0] prev = 2'd0;
      for (int j = 0; j < RUN + 9*D; j++) begin
        logic [1:0] r = 2'($urandom);
        truth[j] = r;
        writeCol({4{prev}}, 4);
        prev = r;
      end
    end
    drain("R4 all bursts delivered, ideal stream");

    // Scenario B: arbitrary decisions with uneven spacing (R5, R6, R2)
    doReset();
    useTruth = 0;
    curReq = "R5 R6 traced pair";
    for (int j = 0; j < RUN + 7*D; j++) writeCol(8'($urandom), 4 + int'($urandom % 3));
    drain("R4 all bursts delivered, random decisions");

    // Scenario C: priming boundary, then reset during a walk (R3, R1)
    doReset();
    curReq = "R3 R6 traced pair";
    outSeen = 0;
    for (int j = 0; j < RUN - 1; j++) writeCol(8'($urandom), 4);
    for (int i = 0; i < 40; i++) tick();
    check(outSeen == 0, "R3 silent one column short", outSeen, 0);
    writeCol(8'($urandom), 4);
    for (int i = 0; i < L + 2*D + 4; i++) tick();
    check(outSeen == D, "R4 one burst at priming", outSeen, D);
    for (int j = 0; j < D; j++) writeCol(8'($urandom), 4);
    for (int i = 0; i < 5; i++) tick();
    doReset();
    outSeen = 0;
    for (int i = 0; i < L + 2*D + 4; i++) tick();
    check(outSeen == 0, "R1 cut-off walk emits nothing", outSeen, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end
endmodule